// File: doc/BRIEF.md
# Indirect Configuration Register Access Bridge

This block sits on the host side of a CPU I/O port bus and lets software reach the configuration registers of several devices through just two fixed I/O ports. Software first writes a target selector into the address port at I/O address 0xCF8. The selector holds an enable flag and picks a device, a function and a dword register. Later reads and writes to the data port at I/O address 0xCFC are sent to the selected register, and read results come back on the same bus. All devices share this one access path. No device has a decode of its own in the I/O or memory map.

For stand-alone testing, the block contains a small model of each device's 256-byte configuration space. The model has the following registers:
- a read-only identification dword;
- a freely writable control dword;
- two programmable base address registers, one for a memory resource and one for an I/O resource. Each has a power-of-two size that depends on the device index, so firmware can size them by writing all ones.

Every claimed access is answered one clock after its request, with the read data valid in that same cycle.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset the address port reads 0x0000_0000, and `io_ack` stays low until a claimed request has been made.
- R2: The address port (I/O address 0x0CF8) keeps bit 31 (enable), bits 15:11 (device), bits 10:8 (function) and bits 7:2 (dword offset). All other bits, including bits 1:0, read back as zero. It changes only on a write to 0x0CF8.
- R3: A request to 0x0CF8 or 0x0CFC is acknowledged exactly one cycle later, with read data valid in that cycle. A request to any other I/O address is never acknowledged and changes no state.
- R4: A data port (0x0CFC) access is a miss in three cases: the enable bit is clear, the device number is not below NUM_DEV, or the function is not 0. A read that misses returns 0xFFFF_FFFF, and a write that misses changes nothing.
- R5: Dword offset 0 reads {device id, vendor id}, where vendor id = 0xA5C0 in bits 15:0 and device id = 0x0100 + device number in bits 31:16. Writes to this dword are ignored.
- R6: Dword offset 4 is a memory base register of size 2^(12+device). Bits at and above that size are writable. All lower bits read 0, so writing all ones reads back ~(2^(12+device) - 1).
- R7: Dword offset 5 is an I/O base register of size 2^(8+device). Bits at and above that size are writable. Bit 0 always reads 1, and the other bits below the size read 0.
- R8: Byte enable bit k gates data byte k (bits 8k+7:8k). A write updates only the enabled bytes, both for the address port and for the fully writable control dword at offset 1.
- R9: All dword offsets other than 0, 1, 4 and 5 read zero, and writes to them have no effect.
- R10: A data port write changes only the register of the selected device. The registers of all other devices keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | One-cycle I/O request strobe |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O byte address |
| io_be | input | 4 | Byte enables for the write data |
| io_wdata | input | 32 | Write data |
| io_ack | output | 1 | Claimed request is complete (one cycle after `io_req`) |
| io_rdata | output | 32 | Read data, valid while `io_ack` is high |

## Verification
The assertions check several behaviours on every cycle:
- every claimed request is acknowledged exactly one cycle later, and nothing else is ever acknowledged;
- a missed data port read returns all ones;
- the address port holds its value unless it is written;
- device registers hold their values unless a write selects that device.

Other behaviours only the bench's sweeps can show, because they depend on values the bench works out itself:
- the per-device identification values;
- the size masks and type bits of both base registers;
- the partial updates made by each of the 16 byte-enable patterns;
- the all-ones results for absent devices and non-zero functions.

// File: rtl/cfg_bridge_pkg.sv
package cfg_bridge_pkg;

  localparam logic [15:0] ADDR_PORT = 16'h0CF8;
  localparam logic [15:0] DATA_PORT = 16'h0CFC;
  localparam logic [31:0] ADDR_KEEP = 32'h8000_FFFC;
  localparam logic [15:0] VENDOR_ID = 16'hA5C0;

  typedef struct packed {
    logic       en;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] dw;
  } cfg_sel_t;

  function automatic cfg_sel_t split_sel(input logic [31:0] a);
    cfg_sel_t s;
    s.en  = a[31];
    s.dev = a[15:11];
    s.fn  = a[10:8];
    s.dw  = a[7:2];
    return s;
  endfunction

  function automatic logic [31:0] merge_bytes(input logic [31:0] old_v,
                                              input logic [31:0] new_v,
                                              input logic [3:0]  be);
    logic [31:0] r;
    for (int k = 0; k < 4; k++)
      r[8*k +: 8] = be[k] ? new_v[8*k +: 8] : old_v[8*k +: 8];
    return r;
  endfunction

  function automatic logic [31:0] size_mask(input int log2sz);
    return 32'hFFFF_FFFF << log2sz;
  endfunction

endpackage

// File: rtl/cfg_addr_latch.sv
module cfg_addr_latch
  import cfg_bridge_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] addr_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)     addr_q <= '0;
    else if (wr_en) addr_q <= merge_bytes(addr_q, wdata, be) & ADDR_KEEP;
  end

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(addr_q));

endmodule

// File: rtl/cfg_dev_space.sv
module cfg_dev_space
  import cfg_bridge_pkg::*;
#(
  parameter int          DEV_IX    = 0,
  parameter int          MEM_LOG2  = 12,
  parameter int          IO_LOG2   = 8,
  parameter logic [15:0] DEVICE_ID = 16'h0100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [5:0]  dw,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);

  localparam logic [31:0] MEM_MASK = size_mask(MEM_LOG2 + DEV_IX);
  localparam logic [31:0] IO_MASK  = size_mask(IO_LOG2 + DEV_IX);

  logic [31:0] ctrl_q, mbar_q, iobar_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      mbar_q  <= '0;
      iobar_q <= '0;
    end else if (wr_en) begin
      case (dw)
        6'd1: ctrl_q  <= merge_bytes(ctrl_q, wdata, be);
        6'd4: mbar_q  <= merge_bytes(mbar_q, wdata, be) & MEM_MASK;
        6'd5: iobar_q <= merge_bytes(iobar_q, wdata, be) & IO_MASK;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (dw)
      6'd0:    rdata = {DEVICE_ID, VENDOR_ID};
      6'd1:    rdata = ctrl_q;
      6'd4:    rdata = mbar_q;
      6'd5:    rdata = iobar_q | 32'h1;
      default: rdata = '0;
    endcase
  end

  // R10
  dev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(ctrl_q) && $stable(mbar_q) && $stable(iobar_q)));

endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfg_bridge_pkg::*;
#(
  parameter int          NUM_DEV     = 4,
  parameter int          MEM_LOG2    = 12,
  parameter int          IO_LOG2     = 8,
  parameter logic [15:0] DEV_ID_BASE = 16'h0100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_req,
  input  logic        io_wr,
  input  logic [15:0] io_addr,
  input  logic [3:0]  io_be,
  input  logic [31:0] io_wdata,
  output logic        io_ack,
  output logic [31:0] io_rdata
);

  logic        hit_addr, hit_data, claim, present, data_wr;
  logic [31:0] addr_q, rd_sel;
  cfg_sel_t    sel;
  logic [31:0] dev_rd [NUM_DEV];

  assign hit_addr = (io_addr == ADDR_PORT);
  assign hit_data = (io_addr == DATA_PORT);
  assign claim    = io_req && (hit_addr || hit_data);
  assign sel      = split_sel(addr_q);
  assign present  = sel.en && (sel.fn == 3'd0) && (32'(sel.dev) < NUM_DEV);
  assign data_wr  = io_req && io_wr && hit_data && present;

  cfg_addr_latch u_addr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(io_req && io_wr && hit_addr),
    .be(io_be), .wdata(io_wdata), .addr_q(addr_q)
  );

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
    cfg_dev_space #(
      .DEV_IX(i), .MEM_LOG2(MEM_LOG2), .IO_LOG2(IO_LOG2),
      .DEVICE_ID(16'(DEV_ID_BASE + 16'(i)))
    ) u_dev (
      .clk(clk), .rst_n(rst_n),
      .wr_en(data_wr && (sel.dev == 5'(i))),
      .dw(sel.dw), .be(io_be), .wdata(io_wdata),
      .rdata(dev_rd[i])
    );
  end

  always_comb begin
    rd_sel = '1;
    for (int i = 0; i < NUM_DEV; i++)
      if (present && (sel.dev == 5'(i))) rd_sel = dev_rd[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_ack   <= 1'b0;
      io_rdata <= '0;
    end else begin
      io_ack <= claim;
      if (claim && !io_wr) io_rdata <= hit_addr ? addr_q : rd_sel;
      else                 io_rdata <= '0;
    end
  end

  // R3
  ack_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    claim |=> io_ack);

  // R3
  ack_unclaim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !claim |=> !io_ack);

  // R4
  miss_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && !io_wr && hit_data && !present) |=> (io_rdata == 32'hFFFF_FFFF));

endmodule

// File: tb/test_cfg_port_bridge.sv
module test_cfg_port_bridge;

  localparam int NDEV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_req = 1'b0, io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [3:0]  io_be = '0;
  logic [31:0] io_wdata = '0;
  logic        io_ack;
  logic [31:0] io_rdata;

  int checks = 0, errors = 0;
  logic        got_ack;
  logic [31:0] got_rd;
  bit          done = 0;

  always #2 clk = ~clk;

  cfg_port_bridge i_cfg_port_bridge (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_wr(io_wr),
    .io_addr(io_addr), .io_be(io_be), .io_wdata(io_wdata),
    .io_ack(io_ack), .io_rdata(io_rdata)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic do_io(input logic wr, input logic [15:0] a,
                       input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    io_req = 1'b1; io_wr = wr; io_addr = a; io_be = be; io_wdata = d;
    @(negedge clk);
    io_req = 1'b0;
    got_ack = io_ack;
    got_rd  = io_rdata;
  endtask

  function automatic logic [31:0] sel_word(input bit en, input int dev, input int fn, input int dw);
    return {en, 15'd0, 5'(dev), 3'(fn), 6'(dw), 2'b00};
  endfunction

  task automatic point(input int dev, input int fn, input int dw);
    do_io(1'b1, 16'h0CF8, 4'hF, sel_word(1'b1, dev, fn, dw));
  endtask

  task automatic cfg_wr(input int dev, input int dw, input logic [3:0] be, input logic [31:0] d);
    point(dev, 0, dw);
    do_io(1'b1, 16'h0CFC, be, d);
  endtask

  task automatic cfg_rd(input int dev, input int fn, input int dw);
    point(dev, fn, dw);
    do_io(1'b0, 16'h0CFC, 4'hF, 32'h0);
  endtask

  function automatic logic [31:0] exp_mbar(input int dev, input logic [31:0] w);
    return w & ~((32'd1 << (12 + dev)) - 32'd1);
  endfunction

  function automatic logic [31:0] exp_iobar(input int dev, input logic [31:0] w);
    return (w & ~((32'd1 << (8 + dev)) - 32'd1)) | 32'd1;
  endfunction

  function automatic logic [31:0] be_bits(input logic [3:0] be);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{be[k]}};
    return m;
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ack idle", 32'(io_ack), 32'd0);
    do_io(1'b0, 16'h0CF8, 4'hF, 32'h0);
    check("R1 ack", 32'(got_ack), 32'd1);
    check("R1 addr reset", got_rd, 32'h0);

    // R2 kept bits
    do_io(1'b1, 16'h0CF8, 4'hF, 32'hFFFF_FFFF);
    check("R2 ack on write", 32'(got_ack), 32'd1);
    do_io(1'b0, 16'h0CF8, 4'hF, 32'h0);
    check("R2 mask", got_rd, 32'h8000_FFFC);
    // R8 address port byte enable
    do_io(1'b1, 16'h0CF8, 4'b0001, 32'h0);
    do_io(1'b0, 16'h0CF8, 4'hF, 32'h0);
    check("R8 addr byte", got_rd, 32'h8000_FF00);

    // R3 unclaimed addresses: no ack and no state change
    begin
      logic [15:0] others [6] = '{16'h0CF4, 16'h0CF9, 16'h0CFA, 16'h0CFD, 16'h0080, 16'h0D00};
      foreach (others[i]) begin
        do_io(1'b1, others[i], 4'hF, 32'h1234_5678);
        check("R3 no ack write", 32'(got_ack), 32'd0);
        do_io(1'b0, others[i], 4'hF, 32'h0);
        check("R3 no ack read", 32'(got_ack), 32'd0);
      end
      do_io(1'b0, 16'h0CF8, 4'hF, 32'h0);
      check("R3 addr untouched", got_rd, 32'h8000_FF00);
    end

    // R5 / R4 sweep of identification over devices and functions
    for (int d = 0; d < 8; d++) begin
      for (int f = 0; f < 2; f++) begin
        logic [31:0] e;
        e = (d < NDEV && f == 0) ? {16'(16'h0100 + d), 16'hA5C0} : 32'hFFFF_FFFF;
        cfg_rd(d, f, 0);
        check("R3 data ack", 32'(got_ack), 32'd1);
        check((d < NDEV && f == 0) ? "R5 id" : "R4 miss ones", got_rd, e);
      end
      if (d < NDEV) begin
        cfg_wr(d, 0, 4'hF, 32'h0);
        cfg_rd(d, 0, 0);
        check("R5 id read-only", got_rd, {16'(16'h0100 + d), 16'hA5C0});
      end
    end

    // R6 / R7 sizing by writing all ones, then a pattern
    for (int d = 0; d < NDEV; d++) begin
      cfg_wr(d, 4, 4'hF, 32'hFFFF_FFFF);
      cfg_rd(d, 0, 4);
      check("R6 mem size", got_rd, exp_mbar(d, 32'hFFFF_FFFF));
      cfg_wr(d, 5, 4'hF, 32'hFFFF_FFFF);
      cfg_rd(d, 0, 5);
      check("R7 io size", got_rd, exp_iobar(d, 32'hFFFF_FFFF));
    end
    // R10 distinct values per device, read back after all are written
    for (int d = 0; d < NDEV; d++) begin
      cfg_wr(d, 4, 4'hF, 32'h1234_5678 + 32'(d) * 32'h1111_1111);
      cfg_wr(d, 5, 4'hF, 32'h8765_4321 - 32'(d) * 32'h0101_0101);
      cfg_wr(d, 1, 4'hF, 32'hC0DE_0000 + 32'(d));
    end
    for (int d = 0; d < NDEV; d++) begin
      cfg_rd(d, 0, 4);
      check("R6 R10 mem pattern", got_rd, exp_mbar(d, 32'h1234_5678 + 32'(d) * 32'h1111_1111));
      cfg_rd(d, 0, 5);
      check("R7 R10 io pattern", got_rd, exp_iobar(d, 32'h8765_4321 - 32'(d) * 32'h0101_0101));
      cfg_rd(d, 0, 1);
      check("R10 ctrl", got_rd, 32'hC0DE_0000 + 32'(d));
    end

    // R8 exhaustive byte enables on control dword of device 1
    for (int b = 0; b < 16; b++) begin
      cfg_wr(1, 1, 4'hF, 32'hFFFF_FFFF);
      cfg_wr(1, 1, 4'(b), 32'h0);
      cfg_rd(1, 0, 1);
      check("R8 ctrl bytes", got_rd, ~be_bits(4'(b)));
    end

    // R4 writes with enable clear, or to function 1, are dropped
    cfg_wr(2, 1, 4'hF, 32'hAAAA_5555);
    do_io(1'b1, 16'h0CF8, 4'hF, sel_word(1'b0, 2, 0, 1));
    do_io(1'b1, 16'h0CFC, 4'hF, 32'h0);
    do_io(1'b0, 16'h0CFC, 4'hF, 32'h0);
    check("R4 disabled read ones", got_rd, 32'hFFFF_FFFF);
    point(2, 1, 1);
    do_io(1'b1, 16'h0CFC, 4'hF, 32'h0);
    cfg_rd(2, 0, 1);
    check("R4 dropped write", got_rd, 32'hAAAA_5555);

    // R9 unimplemented offsets
    for (int w = 2; w < 64; w = w + 5) begin
      if (w == 4 || w == 5) continue;
      cfg_wr(3, w, 4'hF, 32'hFFFF_FFFF);
      cfg_rd(3, 0, w);
      check("R9 unimplemented", got_rd, 32'h0);
    end
    cfg_rd(3, 0, 1);
    check("R9 ctrl untouched", got_rd, 32'hC0DE_0003);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule